// File: doc/BRIEF.md
# SPI Multi-Frame Data Buffer Front End

This block sits between a register bus and the serial shift engine of an SPI controller. Software reaches it through one data port. Writes fill a small bank of transmit slots, and reads return either received frames or a readback of the transmit side, chosen by a select input. A frame-count input sets how many slots make up one transfer group. Its encoding is value k meaning k+1 frames.

The shift engine side has a valid/pop handshake that drains transmit frames in slot order, and a push/ready handshake that stores received frames in slot order. A transmit-empty flag and a one-cycle interrupt pulse tell software when a new group may be written. A receive-full flag tells software when a whole group has arrived. Separate pointers track transmit writes, transmit pops, receive pushes and receive reads. When the enable input rises, every pointer returns to slot 0.

Top module: `spi_frame_buf`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, tx_empty_irq is 0, eng_tx_valid is 0, and rd_data is 0 for both values of rd_sel.
- R2: With rd_sel=0, rd_data shows the receive slot at the receive read pointer. With rd_sel=1, rd_data shows the transmit readback.
- R3: Writes accepted while tx_empty=1 fill transmit slots from slot 0 upward. The engine receives them on eng_tx_data in slot order, one frame per eng_tx_pop.
- R4: When frame_cnt+1 frames have been written, tx_empty clears. Writes made while tx_empty=0 are ignored and change neither the slots nor the readback.
- R5: Transmit readback returns the most recently accepted write while tx_empty=1 (0 if none since reset), and all zeros while tx_empty=0. Reads never move the transmit pointers.
- R6: When the engine pops the last frame of a group, tx_empty sets at the next edge and tx_empty_irq is high for exactly that one cycle. The next write goes to slot 0.
- R7: eng_tx_valid is 1 exactly while en=1 and tx_empty=0.
- R8: Pushed receive frames are stored from slot 0 upward. rx_full sets after frame_cnt+1 pushes. eng_rx_ready is 0 while rx_full=1, and pushes made then are ignored.
- R9: Each read with rd_en=1 and rd_sel=0 advances the receive read pointer, which wraps to slot 0 after slot frame_cnt. The read that wraps it clears rx_full.
- R10: On the cycle en rises from 0 to 1, all four pointers reset to slot 0, tx_empty sets and rx_full clears. Slot contents and the readback value are kept.
- R11: While en=0, writes, pops and pushes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Function enable; a rising edge resets the pointers |
| frame_cnt | input | PW | Frames per group minus one |
| rd_sel | input | 1 | Read source: 0 receive, 1 transmit readback |
| wr_en | input | 1 | Data port write strobe |
| wr_data | input | DW | Data port write value |
| rd_en | input | 1 | Data port read strobe |
| rd_data | output | DW | Data port read value |
| tx_empty | output | 1 | Transmit group may be written |
| tx_empty_irq | output | 1 | One-cycle pulse when tx_empty sets after a drain |
| eng_tx_valid | output | 1 | Transmit frame available to the engine |
| eng_tx_data | output | DW | Transmit frame at the pop pointer |
| eng_tx_pop | input | 1 | Engine takes the offered frame |
| eng_rx_push | input | 1 | Engine delivers a received frame |
| eng_rx_data | input | DW | Received frame |
| eng_rx_ready | output | 1 | Receive slots can accept a frame |
| rx_full | output | 1 | A whole receive group is waiting |

## Verification
The assertions assume the engine pops only while eng_tx_valid is high and pushes only while eng_rx_ready is high. They also assume frame_cnt is held steady within a group. The directed tasks change frame_cnt only between groups, when the block is idle or has just been re-enabled. They issue pops and pushes only after checking the matching handshake output. The only out-of-window strobes are the deliberate ignored-write, ignored-push and disabled-port cases.

// File: rtl/spi_fb_pkg.sv
package spi_fb_pkg;
   typedef enum logic {
      SRC_RX = 1'b0,
      SRC_TX = 1'b1
   } rd_src_e;
endpackage

// File: rtl/spi_fb_ptr.sv
module spi_fb_ptr #(
   parameter int SLOTS = 4,
   localparam int PW = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [PW-1:0] last,
   output logic [PW-1:0] ptr,
   output logic          wrap
);
   assign wrap = step && (ptr == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (clr)  ptr <= '0;
      else if (step) ptr <= wrap ? '0 : ptr + PW'(1);
   end
endmodule

// File: rtl/spi_fb_tx_path.sv
module spi_fb_tx_path #(
   parameter int DW    = 32,
   parameter int SLOTS = 4,
   localparam int PW = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [PW-1:0] last,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          pop,
   output logic          empty,
   output logic          irq,
   output logic [DW-1:0] eng_data,
   output logic [DW-1:0] readback
);
   logic          wr_ok, pop_ok, w_wrap, p_wrap;
   logic [PW-1:0] wptr, pptr;
   logic [DW-1:0] slot_q [SLOTS];
   logic [DW-1:0] last_wr_q;

   assign wr_ok  = en && wr_en && empty;
   assign pop_ok = en && pop && !empty;

   spi_fb_ptr #(.SLOTS(SLOTS)) u_wptr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(wr_ok),
      .last(last), .ptr(wptr), .wrap(w_wrap));

   spi_fb_ptr #(.SLOTS(SLOTS)) u_pptr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(pop_ok),
      .last(last), .ptr(pptr), .wrap(p_wrap));

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        slot_q[i] <= '0;
         else if (wr_ok && wptr == PW'(i))  slot_q[i] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty     <= 1'b1;
         irq       <= 1'b0;
         last_wr_q <= '0;
      end else begin
         irq <= !clr && p_wrap;
         if (wr_ok) last_wr_q <= wr_data;
         if (clr)         empty <= 1'b1;
         else if (w_wrap) empty <= 1'b0;
         else if (p_wrap) empty <= 1'b1;
      end
   end

   assign eng_data = slot_q[pptr];
   assign readback = empty ? last_wr_q : '0;
endmodule

// File: rtl/spi_fb_rx_path.sv
module spi_fb_rx_path #(
   parameter int DW    = 32,
   parameter int SLOTS = 4,
   localparam int PW = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [PW-1:0] last,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          rd,
   output logic          full,
   output logic [DW-1:0] rd_data
);
   logic          push_ok, w_wrap, r_wrap;
   logic [PW-1:0] wptr, rptr;
   logic [DW-1:0] slot_q [SLOTS];

   assign push_ok = en && push && !full;

   spi_fb_ptr #(.SLOTS(SLOTS)) u_wptr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(push_ok),
      .last(last), .ptr(wptr), .wrap(w_wrap));

   spi_fb_ptr #(.SLOTS(SLOTS)) u_rptr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(rd),
      .last(last), .ptr(rptr), .wrap(r_wrap));

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          slot_q[i] <= '0;
         else if (push_ok && wptr == PW'(i))  slot_q[i] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      full <= 1'b0;
      else if (clr)    full <= 1'b0;
      else if (w_wrap) full <= 1'b1;
      else if (r_wrap) full <= 1'b0;
   end

   assign rd_data = slot_q[rptr];
endmodule

// File: rtl/spi_frame_buf.sv
module spi_frame_buf #(
   parameter int DW    = 32,
   parameter int SLOTS = 4,
   localparam int PW = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [PW-1:0] frame_cnt,
   input  logic          rd_sel,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          tx_empty,
   output logic          tx_empty_irq,
   output logic          eng_tx_valid,
   output logic [DW-1:0] eng_tx_data,
   input  logic          eng_tx_pop,
   input  logic          eng_rx_push,
   input  logic [DW-1:0] eng_rx_data,
   output logic          eng_rx_ready,
   output logic          rx_full
);
   import spi_fb_pkg::*;

   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic          en_q, rise;
   logic [DW-1:0] tx_rb, rx_rd;
   rd_src_e       src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en;
   end

   assign rise = en && !en_q;
   assign src  = rd_src_e'(rd_sel);

   spi_fb_tx_path #(.DW(DW), .SLOTS(SLOTS)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(rise), .en(en), .last(frame_cnt),
      .wr_en(wr_en), .wr_data(wr_data), .pop(eng_tx_pop),
      .empty(tx_empty), .irq(tx_empty_irq), .eng_data(eng_tx_data),
      .readback(tx_rb));

   spi_fb_rx_path #(.DW(DW), .SLOTS(SLOTS)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(rise), .en(en), .last(frame_cnt),
      .push(eng_rx_push), .push_data(eng_rx_data),
      .rd(rd_en && src == SRC_RX), .full(rx_full), .rd_data(rx_rd));

   assign rd_data      = (src == SRC_TX) ? tx_rb : rx_rd;
   assign eng_tx_valid = en && !tx_empty;
   assign eng_rx_ready = en && !rx_full;
endmodule

// File: rtl/spi_fb_chk.sv
module spi_fb_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          wr_en,
   input logic          rd_en,
   input logic          rd_sel,
   input logic          eng_tx_pop,
   input logic          eng_rx_push,
   input logic          tx_empty,
   input logic          tx_empty_irq,
   input logic          rx_full,
   input logic [DW-1:0] eng_tx_data
);
   logic en_q, rise;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en;
   end
   assign rise = en && !en_q;

   assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty_irq |=> !tx_empty_irq);

   assert_irq_on_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty_irq |-> (tx_empty && !$past(tx_empty)));

   assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_empty && !(en && eng_tx_pop) && !rise) |=> !tx_empty);

   assert_empty_clear_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> $past(wr_en && en));

   assert_tx_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_empty && !(en && eng_tx_pop) && !rise) |=> $stable(eng_tx_data));

   assert_rx_full_by_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(eng_rx_push && en));

   assert_rx_full_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past((rd_en && !rd_sel) || rise));

   assert_disabled_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(tx_empty));
endmodule

bind spi_frame_buf spi_fb_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .rd_en(rd_en),
   .rd_sel(rd_sel), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
   .tx_empty(tx_empty), .tx_empty_irq(tx_empty_irq), .rx_full(rx_full),
   .eng_tx_data(eng_tx_data));

// File: tb/test_spi_frame_buf.sv
`timescale 1ns/1ps
module test_spi_frame_buf;
   localparam int DW = 32;
   localparam int PW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [PW-1:0] frame_cnt = '0;
   logic          rd_sel = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rd_data;
   logic          tx_empty, tx_empty_irq, eng_tx_valid, eng_rx_ready, rx_full;
   logic [DW-1:0] eng_tx_data;
   logic          eng_tx_pop = 1'b0;
   logic          eng_rx_push = 1'b0;
   logic [DW-1:0] eng_rx_data = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   spi_frame_buf #(.DW(DW), .SLOTS(4)) i_spi_frame_buf (
      .clk(clk), .rst_n(rst_n), .en(en), .frame_cnt(frame_cnt),
      .rd_sel(rd_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .tx_empty(tx_empty), .tx_empty_irq(tx_empty_irq),
      .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
      .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
      .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
      .rx_full(rx_full));

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [DW-1:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_push(input logic [DW-1:0] d);
      @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = d;
      @(negedge clk); eng_rx_push = 1'b0;
   endtask

   task automatic do_pop(output logic [DW-1:0] d);
      @(negedge clk); d = eng_tx_data; eng_tx_pop = 1'b1;
      @(negedge clk); eng_tx_pop = 1'b0;
   endtask

   task automatic do_rx_read(output logic [DW-1:0] d);
      @(negedge clk); rd_sel = 1'b0; #1 d = rd_data; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic tx_readback(output logic [DW-1:0] d);
      @(negedge clk); rd_sel = 1'b1; #1 d = rd_data; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; rd_sel = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 tx_empty", DW'(tx_empty), 1);
      chk("R1 rx_full", DW'(rx_full), 0);
      chk("R1 irq", DW'(tx_empty_irq), 0);
      chk("R1 valid", DW'(eng_tx_valid), 0);
      rd_sel = 1'b1; #1 chk("R1 tx readback", rd_data, 0);
      rd_sel = 1'b0; #1 chk("R1 rx read", rd_data, 0);
   endtask

   task automatic t_tx_group;
      logic [DW-1:0] d;
      @(negedge clk); en = 1'b1; frame_cnt = 2'd3;
      @(negedge clk);
      do_write(32'hA0);
      tx_readback(d); chk("R5 last written", d, 32'hA0);
      do_write(32'hA1); do_write(32'hA2);
      chk("R4 still open", DW'(tx_empty), 1);
      do_write(32'hA3);
      chk("R4 cleared", DW'(tx_empty), 0);
      chk("R7 valid", DW'(eng_tx_valid), 1);
      tx_readback(d); chk("R5 zero while full", d, 0);
      do_write(32'hEE);
      tx_readback(d); chk("R4 ignored write readback", d, 0);
      for (int i = 0; i < 4; i++) begin
         chk("R6 no irq before last", DW'(tx_empty_irq), 0);
         do_pop(d); chk("R3 pop order", d, 32'hA0 + DW'(i));
      end
      chk("R6 empty set", DW'(tx_empty), 1);
      chk("R6 irq pulse", DW'(tx_empty_irq), 1);
      chk("R7 valid off", DW'(eng_tx_valid), 0);
      @(negedge clk); chk("R6 irq one cycle", DW'(tx_empty_irq), 0);
      tx_readback(d); chk("R5 readback after drain", d, 32'hA3);
   endtask

   task automatic t_tx_short;
      logic [DW-1:0] d;
      frame_cnt = 2'd1;
      do_write(32'hB0);
      tx_readback(d); tx_readback(d);
      chk("R5 readback repeat", d, 32'hB0);
      do_write(32'hB1);
      chk("R4 two-frame clear", DW'(tx_empty), 0);
      do_pop(d); chk("R6 restart slot 0", d, 32'hB0);
      do_pop(d); chk("R3 second frame", d, 32'hB1);
      chk("R6 empty after two", DW'(tx_empty), 1);
   endtask

   task automatic t_rx;
      logic [DW-1:0] d;
      frame_cnt = 2'd2;
      chk("R8 ready", DW'(eng_rx_ready), 1);
      do_push(32'hC0); do_push(32'hC1);
      chk("R8 not full", DW'(rx_full), 0);
      do_push(32'hC2);
      chk("R8 full", DW'(rx_full), 1);
      chk("R8 ready low", DW'(eng_rx_ready), 0);
      do_push(32'hDD);
      do_rx_read(d); chk("R2 rx slot0", d, 32'hC0);
      do_rx_read(d); chk("R9 rx slot1", d, 32'hC1);
      chk("R9 full held", DW'(rx_full), 1);
      do_rx_read(d); chk("R8 rx slot2 not overwritten", d, 32'hC2);
      chk("R9 full cleared", DW'(rx_full), 0);
      do_rx_read(d); chk("R9 wrap to slot0", d, 32'hC0);
   endtask

   task automatic t_enable_rise;
      logic [DW-1:0] d;
      frame_cnt = 2'd1;
      do_write(32'hD0);
      @(negedge clk); en = 1'b0;
      @(negedge clk); en = 1'b1;
      @(negedge clk);
      chk("R10 empty set", DW'(tx_empty), 1);
      tx_readback(d); chk("R10 readback kept", d, 32'hD0);
      do_rx_read(d); chk("R10 rx from slot0", d, 32'hC0);
      do_write(32'hE0); do_write(32'hE1);
      chk("R10 group full", DW'(tx_empty), 0);
      do_pop(d); chk("R10 tx from slot0", d, 32'hE0);
      do_pop(d); chk("R10 tx slot1", d, 32'hE1);
   endtask

   task automatic t_en_low;
      logic [DW-1:0] d;
      @(negedge clk); en = 1'b0;
      do_push(32'hF0);
      do_write(32'hF1);
      chk("R11 empty kept", DW'(tx_empty), 1);
      chk("R11 rx_full kept", DW'(rx_full), 0);
      tx_readback(d); chk("R11 write ignored", d, 32'hE1);
      @(negedge clk); en = 1'b1;
      @(negedge clk);
      do_rx_read(d); chk("R11 push ignored", d, 32'hC0);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_tx_group();
      t_tx_short();
      t_rx();
      t_enable_rise();
      t_en_low();
      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule